// File: doc/BRIEF.md
# Fan PWM and Interrupt Register Unit

This unit drives the PWM line of a cooling fan and reports fan events to a host. Software reaches it over a plain 32-bit register port. It programs the PWM high time in clock cycles. The PWM period is fixed by a parameter and software can only read it. The fan side of the unit sits in reset until software writes 1 to bit 0 of the run register.

Four event sources feed an interrupt controller. Each source has a mask bit and a sticky pending bit. Software clears a pending bit by writing 1 to it, and the unmasked pending bits drive an active-high level interrupt. The sources are:
- a completed duty change, raised only after a fan-settling interval;
- a tachometer error;
- a duty raise that the hardware itself requested because temperature rose;
- a fresh tachometer measurement.

A duty change started by software and one started by the hardware are told apart: only the hardware-initiated change raises its own source at once. Both kinds then raise the completion source after the settling interval.

Top module: `fan_pwm_unit`

## Requirements
- R1: After reset:
  - pwm_out and irq are low;
  - the run register (0x80) reads 0;
  - the mask register (0x40) reads 0x0000000F, all sources masked;
  - the width register (0x84) reads PERIOD;
  - the pending register (0x44) reads 0.
- R2: The period register (0xC0) always reads PERIOD, and writes to it have no effect.
- R3: While running, pwm_out is high for exactly min(width, PERIOD) cycles of every PERIOD-cycle window. Width 0 keeps it low and width ≥ PERIOD keeps it high.
- R4: While bit 0 of the run register is 0:
  - pwm_out stays low;
  - tach_err, tach_meas and hot_req events are ignored, so pending and width do not change.
- R5: Pending bit 0 is set exactly SETTLE cycles after the clock edge that wrote the width register. A new width write before then restarts the interval.
- R6: A hot_req pulse while running does three things: it loads hot_width into the width register, it sets pending bit 2 at that edge, and it starts the settle interval.
- R7: A tach_err pulse sets pending bit 1, and a tach_meas pulse sets pending bit 3.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear leaves the bit set.
- R9: irq is registered. It is high one cycle after any pending bit whose mask bit is 0 is set. A mask bit of 1 blocks its source.
- R10: The source register (0x48) reads pending AND NOT mask.
- R11: Read data appears on rsp_rdata in the cycle after the read request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | AW | Register byte offset |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 32 | Write data |
| req_rd | input | 1 | Read strobe |
| rsp_rdata | output | 32 | Read data, one cycle after req_rd |
| tach_err | input | 1 | Tachometer error event pulse |
| tach_meas | input | 1 | New tachometer measurement pulse |
| hot_req | input | 1 | Hardware duty-raise request pulse |
| hot_width | input | DW | Width to load on hot_req |
| pwm_out | output | 1 | Fan PWM drive |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is a restart of the settle interval: a second width write lands while the first interval is still counting. The bench writes a width, waits less than SETTLE cycles while watching that irq stays low, then writes again. It counts the cycles to irq from the second write only.

The other hard case is a source event and its write-one-to-clear in the same cycle. A dedicated task drives the tach_err pulse and the pending-register write on the same edge, then reads the register back.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int NSRC = 4;
  // interrupt source bit positions (visible to software)
  localparam int SRC_DONE = 0;
  localparam int SRC_TERR = 1;
  localparam int SRC_HOT  = 2;
  localparam int SRC_MEAS = 3;
  // register offsets
  localparam logic [7:0] OFF_MASK   = 8'h40;
  localparam logic [7:0] OFF_PEND   = 8'h44;
  localparam logic [7:0] OFF_SRC    = 8'h48;
  localparam logic [7:0] OFF_RUN    = 8'h80;
  localparam logic [7:0] OFF_WIDTH  = 8'h84;
  localparam logic [7:0] OFF_PERIOD = 8'hC0;
endpackage

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PERIOD = 16,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] width,
  output logic          pwm_out
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          pwm_q;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run && (DW'(cnt) < width);
  end

  assign pwm_out = pwm_q;

  AST_PWM_LOW_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_out); // R4
endmodule

// File: rtl/fan_pwm_settle.sv
module fan_pwm_settle #(
  parameter int SETTLE = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic kick,
  output logic done
);
  localparam int TW = $clog2(SETTLE + 1);
  localparam logic [TW-1:0] LOAD = TW'(SETTLE);

  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst || !run)       timer <= '0;
    else if (kick)         timer <= LOAD;
    else if (timer != '0)  timer <= timer - 1'b1;
  end

  assign done = (timer == TW'(1)) && !kick;

  AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    timer <= LOAD); // R5
  AST_SETTLE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (run && kick) |=> (timer == LOAD)); // R5
endmodule

// File: rtl/fan_pwm_irq.sv
module fan_pwm_irq
  import fan_pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wd,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      mask  <= '1;
      irq_q <= 1'b0;
    end else begin
      pend  <= (pend & ~clr) | evt;
      if (mask_we) mask <= mask_wd;
      irq_q <= |(pend & ~mask);
    end
  end

  assign irq = irq_q;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((pend & $past(evt)) == $past(evt))); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~clr)) |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr))); // R8
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |=> !irq); // R9
endmodule

// File: rtl/fan_pwm_unit.sv
module fan_pwm_unit
  import fan_pwm_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int SETTLE = 24,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [31:0]   req_wdata,
  input  logic          req_rd,
  output logic [31:0]   rsp_rdata,
  input  logic          tach_err,
  input  logic          tach_meas,
  input  logic          hot_req,
  input  logic [DW-1:0] hot_width,
  output logic          pwm_out,
  output logic          irq
);
  localparam logic [DW-1:0] WIDTH_RST = DW'(PERIOD);
  localparam logic [31:0]   PERIOD_RD = 32'(PERIOD);

  logic          run_q;
  logic [DW-1:0] width_q;
  logic [31:0]   rdata_q;
  logic          wr_width, wr_run, wr_pend, wr_mask;
  logic          hot_take, kick, done;
  logic [NSRC-1:0] evt, pend, mask;

  assign wr_width = req_wr && (req_addr == AW'(OFF_WIDTH));
  assign wr_run   = req_wr && (req_addr == AW'(OFF_RUN));
  assign wr_pend  = req_wr && (req_addr == AW'(OFF_PEND));
  assign wr_mask  = req_wr && (req_addr == AW'(OFF_MASK));
  assign hot_take = hot_req && run_q;
  assign kick     = wr_width || hot_take;

  // run flag and width; host write has priority over a same-cycle hot request
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      width_q <= WIDTH_RST;
    end else begin
      if (wr_run) run_q <= req_wdata[0];
      if (wr_width)      width_q <= req_wdata[DW-1:0];
      else if (hot_take) width_q <= hot_width;
    end
  end

  always_comb begin
    evt           = '0;
    evt[SRC_DONE] = done;
    evt[SRC_TERR] = tach_err  && run_q;
    evt[SRC_HOT]  = hot_take;
    evt[SRC_MEAS] = tach_meas && run_q;
  end

  fan_pwm_gen #(.PERIOD(PERIOD), .DW(DW)) u_gen (
    .clk(clk), .rst(rst), .run(run_q), .width(width_q), .pwm_out(pwm_out)
  );

  fan_pwm_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .run(run_q), .kick(kick), .done(done)
  );

  fan_pwm_irq u_irq (
    .clk(clk), .rst(rst), .evt(evt),
    .clr(wr_pend ? req_wdata[NSRC-1:0] : '0),
    .mask_we(wr_mask), .mask_wd(req_wdata[NSRC-1:0]),
    .pend(pend), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (req_rd) begin
      rdata_q <= '0;
      if      (req_addr == AW'(OFF_RUN))    rdata_q <= {31'd0, run_q};
      else if (req_addr == AW'(OFF_WIDTH))  rdata_q <= 32'(width_q);
      else if (req_addr == AW'(OFF_PERIOD)) rdata_q <= PERIOD_RD;
      else if (req_addr == AW'(OFF_MASK))   rdata_q <= 32'(mask);
      else if (req_addr == AW'(OFF_PEND))   rdata_q <= 32'(pend);
      else if (req_addr == AW'(OFF_SRC))    rdata_q <= 32'(pend & ~mask);
    end
  end

  assign rsp_rdata = rdata_q;

  AST_PERIOD_CONST: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == AW'(OFF_PERIOD)) |=> (rsp_rdata == PERIOD_RD)); // R2
  AST_HOT_IGNORED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_width) |=> $stable(width_q)); // R4
endmodule

// File: tb/fan_pwm_unit_bench.sv
module fan_pwm_unit_bench;
  localparam int CLK_NS = 10;
  localparam int PERIOD = 16;
  localparam int SETTLE = 24;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  req_addr = '0;
  logic        req_wr = 0, req_rd = 0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        tach_err = 0, tach_meas = 0, hot_req = 0;
  logic [31:0] hot_width = '0;
  logic        pwm_out, irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  fan_pwm_unit #(.PERIOD(PERIOD), .SETTLE(SETTLE)) u_fan_pwm_unit (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_wr(req_wr),
    .req_wdata(req_wdata), .req_rd(req_rd), .rsp_rdata(rsp_rdata),
    .tach_err(tach_err), .tach_meas(tach_meas), .hot_req(hot_req),
    .hot_width(hot_width), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_wr = 1;
    @(negedge clk);
    req_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_addr = a; req_rd = 1;
    @(negedge clk);
    req_rd = 0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic high_count(output int hi);
    hi = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic pulse_terr();
    @(negedge clk); tach_err = 1;
    @(negedge clk); tach_err = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pwm_out", 32'(pwm_out), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h80, d); chk("R1 run", d, 0);
    rd(8'h40, d); chk("R1 mask", d, 32'hF);
    rd(8'h84, d); chk("R1 width", d, PERIOD);
    rd(8'h44, d); chk("R1 pending", d, 0);
    rd(8'hC0, d); chk("R2 period", d, PERIOD);
    wr(8'hC0, 32'd5);
    rd(8'hC0, d); chk("R2 period after write", d, PERIOD);
    rd(8'h10, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_held();
    logic [31:0] d;
    int hi;
    high_count(hi); chk("R4 pwm low in reset", 32'(hi), 0);
    pulse_terr();
    @(negedge clk); hot_width = 3; hot_req = 1;
    @(negedge clk); hot_req = 0;
    rd(8'h44, d); chk("R4 events ignored", d, 0);
    rd(8'h84, d); chk("R4 hot ignored", d, PERIOD);
  endtask

  task automatic t_duty();
    int hi;
    wr(8'h80, 1);
    idle(4); high_count(hi); chk("R3 full duty", 32'(hi), PERIOD);
    wr(8'h84, 5); idle(20); high_count(hi); chk("R3 width 5", 32'(hi), 5);
    wr(8'h84, 0); idle(20); high_count(hi); chk("R3 width 0", 32'(hi), 0);
    wr(8'h84, 20); idle(20); high_count(hi); chk("R3 width over period", 32'(hi), PERIOD);
  endtask

  task automatic t_settle();
    int n;
    bit early;
    idle(SETTLE + 4);
    wr(8'h44, 32'hF);
    wr(8'h40, 32'hE);
    wr(8'h84, 8);
    n = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (irq) begin n = i; break; end
    end
    chk("R5 R9 settle latency", 32'(n), SETTLE + 1);
    wr(8'h44, 32'h1);
    @(negedge clk);
    chk("R8 clear drops irq", 32'(irq), 0);
    // restart of the interval
    wr(8'h84, 9);
    early = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq) early = 1;
    end
    wr(8'h84, 10);
    n = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (irq) begin n = i; break; end
    end
    chk("R5 no early done", 32'(early), 0);
    chk("R5 restart latency", 32'(n), SETTLE + 1);
    wr(8'h44, 32'hF);
  endtask

  task automatic t_hot();
    logic [31:0] d;
    wr(8'h40, 32'hB);
    @(negedge clk); hot_width = 12; hot_req = 1;
    @(negedge clk); hot_req = 0;
    @(negedge clk);
    chk("R6 R9 hot irq", 32'(irq), 1);
    rd(8'h84, d); chk("R6 width loaded", d, 12);
    idle(SETTLE + 4);
    rd(8'h44, d); chk("R6 hot then done", d, 32'h5);
  endtask

  task automatic t_tach();
    logic [31:0] d;
    wr(8'h44, 32'hF);
    wr(8'h40, 32'h0);
    pulse_terr();
    rd(8'h44, d); chk("R7 tach err bit1", d, 32'h2);
    @(negedge clk); tach_meas = 1;
    @(negedge clk); tach_meas = 0;
    rd(8'h44, d); chk("R7 meas bit3", d, 32'hA);
    wr(8'h40, 32'h8);
    rd(8'h48, d); chk("R10 source", d, 32'h2);
    chk("R9 irq unmasked", 32'(irq), 1);
    wr(8'h40, 32'hF);
    @(negedge clk);
    chk("R9 irq masked", 32'(irq), 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk);
    req_addr = 8'h44; req_wdata = 32'h2; req_wr = 1; tach_err = 1;
    @(negedge clk);
    req_wr = 0; tach_err = 0;
    rd(8'h44, d); chk("R8 event beats clear", d, 32'hA);
    wr(8'h44, 32'h8);
    rd(8'h44, d); chk("R8 clear bit3", d, 32'h2);
    wr(8'h44, 32'h0);
    rd(8'h44, d); chk("R8 zero write no effect", d, 32'h2);
    wr(8'h44, 32'h2);
    rd(8'h44, d); chk("R8 clear bit1", d, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int hi;
    wr(8'h80, 0);
    @(negedge clk);
    high_count(hi); chk("R4 pwm low after stop", 32'(hi), 0);
    @(negedge clk); hot_width = 2; hot_req = 1;
    @(negedge clk); hot_req = 0;
    rd(8'h84, d); chk("R4 hot ignored when stopped", d, 12);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 0;
    t_reset();
    t_held();
    t_duty();
    t_settle();
    t_hot();
    t_tach();
    t_w1c();
    t_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule